// File: doc/BRIEF.md
# Event Detector with Time Stamp

This block watches one external event line. The line is sampled on a slow timebase: either every clock, or only on one of three periodic strobes that arrive at quarter-second, half-second and one-second intervals. A high sample counts as an event. An optional filter demands two high samples in a row, so that a bouncing switch contact does not register.

A qualified event sets a sticky status flag. On the first event after the flag was cleared, the block also copies the current clock and calendar fields into a stamp register. The flag can drive an active-low detect output and a request that stops the timekeeping counters. The flag stays set until the host writes a zero to it.

Detection can be switched off as a whole. A separate control decides whether detection continues while the device runs from its backup supply. When detection is inactive, the event line is gated off and has no effect.

Top module: `evt_stamp_top`

## Requirements
- R1: After reset, the flag is 0, the stamp is all zeros, the detect output is high and the freeze request is 0.
- R2: With detection active and rate code 0 (sample every clock) and the filter off, a high input at a clock edge sets the flag after that edge. The stamp then holds the value that time_i had at that edge.
- R3: The flag stays 1 until a clear write (clr_we_i=1 with clr_data_i=0) occurs at an edge where no qualifying sample happens. A write with clr_data_i=1 leaves the flag unchanged.
- R4: While the flag is 1, later qualifying samples leave the stamp unchanged. A clear that lets the flag fall does not alter the stamp either.
- R5: det_no is 0 exactly when the flag is 1 and out_en_i is 1. Otherwise it is 1.
- R6: freeze_o is 1 exactly when the flag is 1 and freeze_en_i is 1.
- R7: With det_en_i=0, the event input has no effect: the flag does not set.
- R8: With on_batt_i=1, detection works only if batt_allow_i=1. With batt_allow_i=0, the input is ignored.
- R9: Rate codes 1, 2 and 3 sample the input only at edges where strobe_i[0], strobe_i[1] or strobe_i[2], respectively, is 1. A high input at other edges is ignored.
- R10: With filt_en_i=1, an event qualifies only when two consecutive selected samples read high. A single high sample followed by a low one sets nothing.
- R11: When a clear write and a qualifying sample land on the same edge, the detection wins. The flag stays 1 and the stamp takes time_i from that edge. A clear while the input is low clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_pin_i | input | 1 | Event line, high means event |
| strobe_i | input | NUM_STROBES | Sample strobes: [0] 1/4 s, [1] 1/2 s, [2] 1 s |
| time_i | input | NUM_FIELDS*FIELD_W | Current time and date fields |
| det_en_i | input | 1 | Detection enable |
| batt_allow_i | input | 1 | Keep detection active in backup mode |
| on_batt_i | input | 1 | Device running from backup supply |
| rate_sel_i | input | 2 | Sample rate code 0..3 |
| filt_en_i | input | 1 | Two-sample filter enable |
| out_en_i | input | 1 | Detect output enable |
| freeze_en_i | input | 1 | Counter freeze enable |
| clr_we_i | input | 1 | Host write strobe to the flag |
| clr_data_i | input | 1 | Host write data, 0 clears |
| evt_flag_o | output | 1 | Sticky event flag |
| stamp_o | output | NUM_FIELDS*FIELD_W | Latched time stamp |
| det_no | output | 1 | Detect output, active low |
| freeze_o | output | 1 | Request to stop the timekeeping counters |

## Verification
The flag, the stamp and the freeze request change at the edge that takes a qualifying sample. They are therefore visible one cycle after the input that caused them. With the filter on, that point moves to the second high sample. det_no follows the flag and out_en_i within the same cycle.

The bench drives inputs just after the falling edge. A behavioural model is updated at each rising edge and compared against the outputs 2 ns later. Directed checks read the outputs one falling edge after the stimulus, so each result is read in the cycle it is due.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int RATE_W = 2;
  typedef enum logic [RATE_W-1:0] {
    RATE_CONT = 2'd0,
    RATE_QTR  = 2'd1,
    RATE_HALF = 2'd2,
    RATE_SEC  = 2'd3
  } rate_e;
endpackage

// File: rtl/evt_rate_sel.sv
module evt_rate_sel
  import evt_pkg::*;
#(
  parameter int NUM_STROBES = 3
) (
  input  logic [RATE_W-1:0]      rate_i,
  input  logic [NUM_STROBES-1:0] strobe_i,
  output logic                   tick_o
);
  localparam int NUM_TAPS = 2**RATE_W;
  logic [NUM_TAPS-1:0] taps;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_cont
      assign taps[k] = 1'b1;
    end else if (k <= NUM_STROBES) begin : g_strb
      assign taps[k] = strobe_i[k-1];
    end else begin : g_none
      assign taps[k] = 1'b0;
    end
  end

  assign tick_o = taps[rate_i];
endmodule

// File: rtl/evt_qualify.sv
module evt_qualify (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic active_i,
  input  logic tick_i,
  input  logic filt_en_i,
  output logic hit_o
);
  logic gated;
  logic prev_hi_q;

  // line is gated off whenever detection is inactive
  assign gated = pin_i & active_i;
  assign hit_o = tick_i & gated & (~filt_en_i | prev_hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_hi_q <= 1'b0;
    else if (!active_i) prev_hi_q <= 1'b0;
    else if (tick_i)   prev_hi_q <= gated;
  end
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 6,
  localparam int TIME_W    = FIELD_W * NUM_FIELDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              flag_o,
  output logic [TIME_W-1:0] stamp_o
);
  logic flag_q;
  logic load;

  // first event since the last clear; a clear on the same edge re-arms
  assign load = hit_i & (~flag_q | clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [FIELD_W-1:0] fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   fld_q <= '0;
      else if (load) fld_q <= time_i[f*FIELD_W +: FIELD_W];
    end
    assign stamp_o[f*FIELD_W +: FIELD_W] = fld_q;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top
  import evt_pkg::*;
#(
  parameter int NUM_STROBES = 3,
  parameter int FIELD_W     = 8,
  parameter int NUM_FIELDS  = 6,
  localparam int TIME_W     = FIELD_W * NUM_FIELDS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   evt_pin_i,
  input  logic [NUM_STROBES-1:0] strobe_i,
  input  logic [TIME_W-1:0]      time_i,
  input  logic                   det_en_i,
  input  logic                   batt_allow_i,
  input  logic                   on_batt_i,
  input  logic [RATE_W-1:0]      rate_sel_i,
  input  logic                   filt_en_i,
  input  logic                   out_en_i,
  input  logic                   freeze_en_i,
  input  logic                   clr_we_i,
  input  logic                   clr_data_i,
  output logic                   evt_flag_o,
  output logic [TIME_W-1:0]      stamp_o,
  output logic                   det_no,
  output logic                   freeze_o
);
  logic active, tick, hit, clr;

  assign active = det_en_i & (~on_batt_i | batt_allow_i);
  assign clr    = clr_we_i & ~clr_data_i;

  evt_rate_sel #(.NUM_STROBES(NUM_STROBES)) u_rate (
    .rate_i   (rate_sel_i),
    .strobe_i (strobe_i),
    .tick_o   (tick)
  );

  evt_qualify u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (evt_pin_i),
    .active_i  (active),
    .tick_i    (tick),
    .filt_en_i (filt_en_i),
    .hit_o     (hit)
  );

  evt_capture #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .clr_i   (clr),
    .time_i  (time_i),
    .flag_o  (evt_flag_o),
    .stamp_o (stamp_o)
  );

  assign det_no   = ~(evt_flag_o & out_en_i);
  assign freeze_o = evt_flag_o & freeze_en_i;
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
  parameter int TIME_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_pin_i,
  input logic              det_en_i,
  input logic              batt_allow_i,
  input logic              on_batt_i,
  input logic              out_en_i,
  input logic              clr_we_i,
  input logic              clr_data_i,
  input logic              evt_flag_o,
  input logic [TIME_W-1:0] stamp_o,
  input logic              det_no,
  input logic              freeze_o
);
  a_r2_low_pin_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_pin_i && !evt_flag_o) |=> !evt_flag_o);

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_flag_o && !(clr_we_i && !clr_data_i)) |=> evt_flag_o);

  a_r4_stamp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_flag_o && !(clr_we_i && !clr_data_i)) |=> $stable(stamp_o));

  a_r5_det_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_no |-> (evt_flag_o && out_en_i));

  a_r6_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> evt_flag_o);

  a_r7_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en_i && !evt_flag_o) |=> !evt_flag_o);

  a_r8_batt_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_batt_i && !batt_allow_i && !evt_flag_o) |=> !evt_flag_o);
endmodule

bind evt_stamp_top evt_stamp_chk #(.TIME_W(TIME_W)) chk_i (.*);

// File: tb/evt_stamp_top_tb_top.sv
`timescale 1ns/1ps
module evt_stamp_top_tb_top;
  localparam int TW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 0, det_en = 0, batt_allow = 0, on_batt = 0, filt = 0;
  logic out_en = 0, frz_en = 0, clr_we = 0, clr_data = 0;
  logic [1:0] rate = 0;
  logic [2:0] strobe = 0;
  logic [TW-1:0] tval = '0;
  logic flag, det_n, frz;
  logic [TW-1:0] stamp;

  int checks = 0, fails = 0, sc = 0;
  string cur_req = "R1";

  // model state
  bit m_flag = 0, m_prev = 0;
  logic [TW-1:0] m_stamp = '0;

  always #2.5 clk = ~clk;

  evt_stamp_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_pin_i(pin), .strobe_i(strobe), .time_i(tval),
    .det_en_i(det_en), .batt_allow_i(batt_allow), .on_batt_i(on_batt), .rate_sel_i(rate),
    .filt_en_i(filt), .out_en_i(out_en), .freeze_en_i(frz_en), .clr_we_i(clr_we),
    .clr_data_i(clr_data), .evt_flag_o(flag), .stamp_o(stamp), .det_no(det_n), .freeze_o(frz)
  );

  // timebase and strobes change at the falling edge
  always @(negedge clk) begin
    sc     <= sc + 1;
    tval   <= {8'h20, 8'h06, 8'h15, 8'h09, 8'h30, 8'(sc)} + {40'd0, 8'd1};
    strobe <= {((sc + 1) % 16 == 0), ((sc + 1) % 8 == 0), ((sc + 1) % 4 == 0)};
  end

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_prev = 0; m_stamp = '0;
    end else begin
      bit act, g, tk, hit, cl;
      act = det_en && (!on_batt || batt_allow);
      g   = pin && act;
      tk  = (rate == 0) ? 1'b1 : strobe[rate-1];
      hit = tk && g && (!filt || m_prev);
      cl  = clr_we && !clr_data;
      if (hit && (!m_flag || cl)) m_stamp = tval;
      if (hit) m_flag = 1; else if (cl) m_flag = 0;
      if (!act) m_prev = 0; else if (tk) m_prev = g;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (flag !== m_flag || stamp !== m_stamp || det_n !== !(m_flag && out_en) ||
          frz !== (m_flag && frz_en)) begin
        fails++;
        $display("FAIL %s model: flag=%0b stamp=%h detn=%0b frz=%0b exp flag=%0b stamp=%h",
                 cur_req, flag, stamp, det_n, frz, m_flag, m_stamp);
      end
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle pin pulse, returns time_i seen at the sampling edge
  task automatic pulse(output logic [TW-1:0] t);
    pin = 1; t = tval; nxt(); pin = 0;
  endtask

  task automatic do_clear();
    clr_we = 1; clr_data = 0; nxt(); clr_we = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [TW-1:0] t0, t1;
    nxt(); nxt();
    rst_n = 1; nxt();
    cur_req = "R1";
    chk("R1 flag", TW'(flag), 0);
    chk("R1 stamp", stamp, 0);
    chk("R1 det_no", TW'(det_n), 1);
    chk("R1 freeze", TW'(frz), 0);

    cur_req = "R2";
    det_en = 1; out_en = 1; frz_en = 1;
    nxt();
    pulse(t0); nxt();
    chk("R2 flag", TW'(flag), 1);
    chk("R2 stamp", stamp, t0);
    chk("R5 det low", TW'(det_n), 0);
    chk("R6 freeze", TW'(frz), 1);

    cur_req = "R3";
    repeat (3) nxt();
    chk("R3 sticky", TW'(flag), 1);
    cur_req = "R4";
    pulse(t1); nxt();
    chk("R4 stamp kept", stamp, t0);
    cur_req = "R3";
    clr_we = 1; clr_data = 1; nxt(); clr_we = 0; nxt();
    chk("R3 write1 no clear", TW'(flag), 1);
    do_clear(); nxt();
    chk("R3 cleared", TW'(flag), 0);
    chk("R4 stamp after clear", stamp, t0);
    chk("R5 det high", TW'(det_n), 1);

    cur_req = "R5";
    out_en = 0; frz_en = 0;
    pulse(t1); nxt();
    chk("R5 out disabled", TW'(det_n), 1);
    chk("R6 freeze disabled", TW'(frz), 0);
    out_en = 1; frz_en = 1; nxt();
    chk("R5 out reenabled", TW'(det_n), 0);
    do_clear(); nxt();

    cur_req = "R7";
    det_en = 0; pin = 1; repeat (5) nxt(); pin = 0; nxt();
    chk("R7 disabled", TW'(flag), 0);
    det_en = 1;

    cur_req = "R8";
    on_batt = 1; batt_allow = 0;
    pin = 1; repeat (3) nxt(); pin = 0; nxt();
    chk("R8 blocked", TW'(flag), 0);
    batt_allow = 1;
    pulse(t1); nxt();
    chk("R8 allowed", TW'(flag), 1);
    do_clear(); on_batt = 0; batt_allow = 0; nxt();

    cur_req = "R9";
    rate = 2'd3;
    while (strobe[2]) nxt();
    pulse(t1); nxt();
    chk("R9 off-strobe ignored", TW'(flag), 0);
    while (!strobe[2]) nxt();
    pulse(t1); nxt();
    chk("R9 on-strobe set", TW'(flag), 1);
    chk("R9 stamp", stamp, t1);
    do_clear();
    rate = 2'd1;
    while (!strobe[0]) nxt();
    pulse(t1); nxt();
    chk("R9 rate1 set", TW'(flag), 1);
    do_clear();
    rate = 2'd0; nxt();

    cur_req = "R10";
    filt = 1;
    pulse(t1); nxt();
    chk("R10 single rejected", TW'(flag), 0);
    pin = 1; nxt();
    chk("R10 first of two", TW'(flag), 0);
    t1 = tval; nxt(); pin = 0;
    chk("R10 second sets", TW'(flag), 1);
    chk("R10 stamp", stamp, t1);
    filt = 0; do_clear(); nxt();

    cur_req = "R11";
    pin = 1; nxt();
    clr_we = 1; clr_data = 0; t1 = tval; nxt(); clr_we = 0;
    chk("R11 detect wins", TW'(flag), 1);
    chk("R11 stamp refreshed", stamp, t1);
    pin = 0; nxt();
    do_clear();
    chk("R11 low clears", TW'(flag), 0);
    repeat (4) nxt();
    finish_run();
  end
endmodule